// File: doc/BRIEF.md
# Speculative Cache Line Tag Tracker

This block holds the speculation status bits for the lines of a small data cache in one of four cores that run threads of a single program out of order. For every line it keeps a valid bit, a modified bit and a pre-invalidate bit. For every word it keeps a read bit and a written bit. It watches the local core's loads and stores. It also watches stores from the other cores, which it snoops off a shared write bus. It compares the writing core's 2-bit thread order number with the local core's number, so it knows whether each snooped write came from an earlier thread or a later one.

A store from an earlier thread to a word that the local thread has already read, but has not itself written, breaks read-after-write order. The tracker then raises a one-cycle violation pulse, and the local thread has to restart. The restart and commit inputs clean up the speculative state: a restart drops lines that hold speculative data, and a commit drops lines that a later thread wrote. The data array, the refill path and bus arbitration sit outside the block. A fill input only marks a line as present.

Every input is a single-cycle event, sampled on each rising clock edge. The block always takes what it is given. It has no ready signal and applies no back-pressure. All status outputs come straight from registers. An input event shows on the outputs one clock after the edge that sampled it.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset, all line valid, modified and pre-invalidate bits are 0, all word read and written bits are 0, and the violation output is 0.
- R2: A fill marks its line valid and clears that line's modified, pre-invalidate, read and written bits. Local accesses and snooped stores to a line that is not valid change nothing.
- R3: A local store sets the written bit of the addressed word and the modified bit of its line. Word bits are reported at flat index line*WORDS+word.
- R4: A local load sets the read bit of the addressed word, unless that word's written bit is already set.
- R5: A snooped store from a core whose order number is lower than the local core's (an earlier thread) sets the line's modified bit. If the target word has its read bit set and its written bit clear, the violation output is 1 in the following cycle.
- R6: A snooped store from a core whose order number is higher than the local core's (a later thread) sets the line's pre-invalidate bit and never raises a violation.
- R7: A snooped store to a word whose written bit is set raises no violation, even when the word's read bit is also set.
- R8: A snooped store whose source core number equals the local core number has no effect.
- R9: The violation output stays high for one cycle only. After a pulse, no further pulse occurs until restart is asserted. After the restart, violations are detected again.
- R10: On restart, every valid line whose modified bit is set becomes invalid, and all modified, pre-invalidate, read and written bits are cleared by the next cycle. If restart and commit are asserted together, restart wins.
- R11: On commit, every line whose pre-invalidate bit is set becomes invalid, and all modified, pre-invalidate, read and written bits are cleared by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_core_i | input | 2 | Number of the core this tracker belongs to |
| ranks_i | input | 8 | Thread order number for each core; core k sits in bits [2k+1:2k] |
| fill_valid_i | input | 1 | Mark a line as present |
| fill_line_i | input | 3 | Line being filled |
| acc_valid_i | input | 1 | Local access event |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_line_i | input | 3 | Line of the local access |
| acc_word_i | input | 2 | Word of the local access |
| snp_valid_i | input | 1 | Snooped store event on the write bus |
| snp_core_i | input | 2 | Core that issued the snooped store |
| snp_line_i | input | 3 | Line of the snooped store |
| snp_word_i | input | 2 | Word of the snooped store |
| restart_i | input | 1 | Discard the speculative state of the local thread |
| commit_i | input | 1 | Retire the local thread |
| viol_o | output | 1 | One-cycle pulse on a read-after-write order violation |
| line_valid_o | output | 8 | Valid bit for each line |
| line_mod_o | output | 8 | Modified bit for each line |
| line_pinv_o | output | 8 | Pre-invalidate bit for each line |
| word_rd_o | output | 32 | Read bits, at index line*4+word |
| word_wr_o | output | 32 | Written bits, at index line*4+word |

## Verification
The hardest state to reach is a violation that the pending latch has masked, followed by the point where detection starts again. To get there, a first pulse has to leave the latch set. A second qualifying snoop must then pass without a pulse, and detection must return only after a restart. The bench reaches this state in steps. It loads a word and snoops an earlier-thread store to it. It repeats the store from a second earlier core. It restarts while commit is also high. Finally it builds a fresh load and snoop pair on a line that survived the restart, and checks that the pulse comes back.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;
  // How a snooped store relates to the local thread
  typedef enum logic [1:0] {
    SNP_NONE    = 2'd0,
    SNP_OLDER   = 2'd1,
    SNP_YOUNGER = 2'd2
  } snp_class_e;
endpackage

// File: rtl/spec_rank_cmp.sv
module spec_rank_cmp
  import spec_tag_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int RANK_W    = 2,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES*RANK_W-1:0] ranks_i,
  input  logic [CORE_W-1:0]           local_core_i,
  input  logic                        snp_valid_i,
  input  logic [CORE_W-1:0]           snp_core_i,
  output snp_class_e                  snp_class_o
);
  logic [RANK_W-1:0] local_rank;
  logic [RANK_W-1:0] src_rank;

  always_comb begin
    local_rank  = ranks_i[int'(local_core_i)*RANK_W +: RANK_W];
    src_rank    = ranks_i[int'(snp_core_i)*RANK_W +: RANK_W];
    snp_class_o = SNP_NONE;
    if (snp_valid_i && (snp_core_i != local_core_i)) begin
      if (src_rank < local_rank)      snp_class_o = SNP_OLDER;
      else if (src_rank > local_rank) snp_class_o = SNP_YOUNGER;
    end
  end
endmodule

// File: rtl/spec_line_state.sv
module spec_line_state
  import spec_tag_pkg::*;
#(
  parameter int WORDS   = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_i,
  input  logic              acc_sel_i,
  input  logic              acc_write_i,
  input  logic [WORD_W-1:0] acc_word_i,
  input  logic              snp_sel_i,
  input  snp_class_e        snp_class_i,
  input  logic [WORD_W-1:0] snp_word_i,
  input  logic              restart_i,
  input  logic              commit_i,
  output logic              valid_o,
  output logic              mod_o,
  output logic              pinv_o,
  output logic [WORDS-1:0]  rd_o,
  output logic [WORDS-1:0]  wr_o,
  output logic              viol_hit_o
);
  logic             valid_q, mod_q, pinv_q;
  logic [WORDS-1:0] rd_q, wr_q;
  logic             acc_live, snp_live;

  assign acc_live = acc_sel_i && valid_q;
  assign snp_live = snp_sel_i && valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mod_q   <= 1'b0;
      pinv_q  <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (restart_i) begin
      valid_q <= valid_q && !mod_q;
      mod_q   <= 1'b0;
      pinv_q  <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (commit_i) begin
      valid_q <= valid_q && !pinv_q;
      mod_q   <= 1'b0;
      pinv_q  <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      mod_q   <= 1'b0;
      pinv_q  <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      if (acc_live) begin
        if (acc_write_i) begin
          wr_q[acc_word_i] <= 1'b1;
          mod_q            <= 1'b1;
        end else if (!wr_q[acc_word_i]) begin
          rd_q[acc_word_i] <= 1'b1;
        end
      end
      if (snp_live) begin
        if (snp_class_i == SNP_OLDER)   mod_q  <= 1'b1;
        if (snp_class_i == SNP_YOUNGER) pinv_q <= 1'b1;
      end
    end
  end

  assign viol_hit_o = snp_live && (snp_class_i == SNP_OLDER) &&
                      rd_q[snp_word_i] && !wr_q[snp_word_i];

  assign valid_o = valid_q;
  assign mod_o   = mod_q;
  assign pinv_o  = pinv_q;
  assign rd_o    = rd_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/spec_viol_ctrl.sv
module spec_viol_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic restart_i,
  output logic viol_o
);
  logic pending_q, viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      viol_q    <= 1'b0;
    end else if (restart_i) begin
      pending_q <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      viol_q    <= hit_i && !pending_q;
      pending_q <= pending_q || hit_i;
    end
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker
  import spec_tag_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int WORDS     = 4,
  parameter int NUM_CORES = 4,
  parameter int RANK_W    = 2,
  localparam int LINE_W   = $clog2(LINES),
  localparam int WORD_W   = $clog2(WORDS),
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int BITS     = LINES*WORDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CORE_W-1:0]           local_core_i,
  input  logic [NUM_CORES*RANK_W-1:0] ranks_i,
  input  logic                        fill_valid_i,
  input  logic [LINE_W-1:0]           fill_line_i,
  input  logic                        acc_valid_i,
  input  logic                        acc_write_i,
  input  logic [LINE_W-1:0]           acc_line_i,
  input  logic [WORD_W-1:0]           acc_word_i,
  input  logic                        snp_valid_i,
  input  logic [CORE_W-1:0]           snp_core_i,
  input  logic [LINE_W-1:0]           snp_line_i,
  input  logic [WORD_W-1:0]           snp_word_i,
  input  logic                        restart_i,
  input  logic                        commit_i,
  output logic                        viol_o,
  output logic [LINES-1:0]            line_valid_o,
  output logic [LINES-1:0]            line_mod_o,
  output logic [LINES-1:0]            line_pinv_o,
  output logic [BITS-1:0]             word_rd_o,
  output logic [BITS-1:0]             word_wr_o
);
  snp_class_e       snp_class;
  logic [LINES-1:0] hit_vec;

  spec_rank_cmp #(.NUM_CORES(NUM_CORES), .RANK_W(RANK_W)) u_rank (
    .ranks_i      (ranks_i),
    .local_core_i (local_core_i),
    .snp_valid_i  (snp_valid_i),
    .snp_core_i   (snp_core_i),
    .snp_class_o  (snp_class)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic fill_sel, acc_sel, snp_sel;
    assign fill_sel = fill_valid_i && (fill_line_i == LINE_W'(g));
    assign acc_sel  = acc_valid_i  && (acc_line_i  == LINE_W'(g));
    assign snp_sel  = (snp_class != SNP_NONE) && (snp_line_i == LINE_W'(g));

    spec_line_state #(.WORDS(WORDS)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_i      (fill_sel),
      .acc_sel_i   (acc_sel),
      .acc_write_i (acc_write_i),
      .acc_word_i  (acc_word_i),
      .snp_sel_i   (snp_sel),
      .snp_class_i (snp_class),
      .snp_word_i  (snp_word_i),
      .restart_i   (restart_i),
      .commit_i    (commit_i),
      .valid_o     (line_valid_o[g]),
      .mod_o       (line_mod_o[g]),
      .pinv_o      (line_pinv_o[g]),
      .rd_o        (word_rd_o[g*WORDS +: WORDS]),
      .wr_o        (word_wr_o[g*WORDS +: WORDS]),
      .viol_hit_o  (hit_vec[g])
    );
  end

  spec_viol_ctrl u_viol (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (|hit_vec),
    .restart_i (restart_i),
    .viol_o    (viol_o)
  );
endmodule

// File: rtl/spec_tag_tracker_chk.sv
module spec_tag_tracker_chk #(
  parameter int LINES = 8,
  parameter int WORDS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   snp_valid_i,
  input logic                   restart_i,
  input logic                   commit_i,
  input logic                   viol_o,
  input logic [LINES-1:0]       line_valid_o,
  input logic [LINES-1:0]       line_mod_o,
  input logic [LINES-1:0]       line_pinv_o,
  input logic [LINES*WORDS-1:0] word_rd_o,
  input logic [LINES*WORDS-1:0] word_wr_o
);
  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (word_rd_o == '0 && word_wr_o == '0 && line_mod_o == '0 && line_pinv_o == '0));

  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> ((line_valid_o & $past(line_mod_o)) == '0));

  // R11
  commit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !restart_i) |=> ((line_valid_o & $past(line_pinv_o)) == '0 &&
                                  word_rd_o == '0 && word_wr_o == '0));

  // R9
  viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> !viol_o);

  // R5
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ($past(snp_valid_i) && !$past(restart_i)));
endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(.LINES(LINES), .WORDS(WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snp_valid_i  (snp_valid_i),
  .restart_i    (restart_i),
  .commit_i     (commit_i),
  .viol_o       (viol_o),
  .line_valid_o (line_valid_o),
  .line_mod_o   (line_mod_o),
  .line_pinv_o  (line_pinv_o),
  .word_rd_o    (word_rd_o),
  .word_wr_o    (word_wr_o)
);

// File: tb/spec_tag_tracker_bench.sv
module spec_tag_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  local_core_i = 2'd1;
  // core0 rank0, core1 rank2 (local), core2 rank3, core3 rank1
  logic [7:0]  ranks_i = {2'd1, 2'd3, 2'd2, 2'd0};
  logic        fill_valid_i = 1'b0;
  logic [2:0]  fill_line_i = '0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [2:0]  acc_line_i = '0;
  logic [1:0]  acc_word_i = '0;
  logic        snp_valid_i = 1'b0;
  logic [1:0]  snp_core_i = '0;
  logic [2:0]  snp_line_i = '0;
  logic [1:0]  snp_word_i = '0;
  logic        restart_i = 1'b0, commit_i = 1'b0;
  logic        viol_o;
  logic [7:0]  line_valid_o, line_mod_o, line_pinv_o;
  logic [31:0] word_rd_o, word_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spec_tag_tracker u_spec_tag_tracker (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fill_valid_i = 0; acc_valid_i = 0; acc_write_i = 0; snp_valid_i = 0;
    restart_i = 0; commit_i = 0;
  endtask

  // Each helper drives for one edge and returns at the following falling edge
  task automatic do_fill(input int ln);
    @(negedge clk); idle(); fill_valid_i = 1; fill_line_i = 3'(ln);
    @(negedge clk); idle();
  endtask

  task automatic do_acc(input bit wr, input int ln, input int wd);
    @(negedge clk); idle(); acc_valid_i = 1; acc_write_i = wr;
    acc_line_i = 3'(ln); acc_word_i = 2'(wd);
    @(negedge clk); idle();
  endtask

  task automatic do_snp(input int core, input int ln, input int wd);
    @(negedge clk); idle(); snp_valid_i = 1; snp_core_i = 2'(core);
    snp_line_i = 3'(ln); snp_word_i = 2'(wd);
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(line_valid_o), 0);
    check("R1 mod", 32'(line_mod_o), 0);
    check("R1 pinv", 32'(line_pinv_o), 0);
    check("R1 rd", word_rd_o, 0);
    check("R1 wr", word_wr_o, 0);
    check("R1 viol", 32'(viol_o), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) do_fill(i);
    check("R2 fill valid", 32'(line_valid_o), 32'h0F);
  endtask

  task automatic t_local();
    do_acc(0, 0, 1);
    check("R4 load sets rd", word_rd_o, 32'h2);
    do_acc(1, 1, 2);
    check("R3 store wr", word_wr_o, 32'h40);
    check("R3 store mod", 32'(line_mod_o), 32'h02);
    do_acc(0, 1, 2);
    check("R4 load after store", word_rd_o, 32'h2);
    do_acc(0, 5, 0);
    check("R2 invalid line load", word_rd_o, 32'h2);
  endtask

  task automatic t_older();
    do_snp(0, 0, 1);
    check("R5 viol pulse", 32'(viol_o), 1);
    check("R5 older sets mod", 32'(line_mod_o), 32'h03);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(viol_o), 0);
    do_snp(3, 0, 1);
    check("R9 masked until restart", 32'(viol_o), 0);
  endtask

  task automatic t_restart();
    @(negedge clk); idle(); restart_i = 1; commit_i = 1;
    @(negedge clk); idle();
    check("R10 mod lines dropped", 32'(line_valid_o), 32'h0C);
    check("R10 rd cleared", word_rd_o, 0);
    check("R10 wr cleared", word_wr_o, 0);
    check("R10 mod cleared", 32'(line_mod_o), 0);
  endtask

  task automatic t_younger();
    do_acc(0, 3, 0);
    do_snp(2, 3, 0);
    check("R6 no viol", 32'(viol_o), 0);
    check("R6 pinv set", 32'(line_pinv_o), 32'h08);
    check("R6 mod untouched", 32'(line_mod_o), 0);
  endtask

  task automatic t_written();
    do_acc(0, 2, 1);
    do_acc(1, 2, 1);
    do_snp(0, 2, 1);
    check("R7 no viol on written", 32'(viol_o), 0);
    check("R7 mod set", 32'(line_mod_o), 32'h04);
  endtask

  task automatic t_own_and_invalid();
    do_acc(0, 2, 2);
    do_snp(1, 2, 2);
    check("R8 own core no viol", 32'(viol_o), 0);
    check("R8 own core pinv", 32'(line_pinv_o), 32'h08);
    check("R8 own core rd", word_rd_o, 32'h1600);
    do_snp(0, 5, 0);
    check("R2 invalid snoop mod", 32'(line_mod_o), 32'h04);
    check("R2 invalid snoop valid", 32'(line_valid_o), 32'h0C);
  endtask

  task automatic t_rearm();
    do_snp(0, 2, 2);
    check("R9 rearmed after restart", 32'(viol_o), 1);
    check("R3 wr kept", word_wr_o, 32'h200);
  endtask

  task automatic t_commit();
    @(negedge clk); idle(); commit_i = 1;
    @(negedge clk); idle();
    check("R11 pinv lines dropped", 32'(line_valid_o), 32'h04);
    check("R11 rd cleared", word_rd_o, 0);
    check("R11 wr cleared", word_wr_o, 0);
    check("R11 pinv cleared", 32'(line_pinv_o), 0);
    check("R11 mod cleared", 32'(line_mod_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_local();
    t_older();
    t_restart();
    t_younger();
    t_written();
    t_own_and_invalid();
    t_rearm();
    t_commit();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule